// File: doc/BRIEF.md
# DMA Translation Cache with Register-Driven Invalidation

This block caches DMA address translations for an I/O address-translation unit. Each of its eight entries is keyed by a 16-bit domain number and a page number. A page is either 4 KB or 2 MB in size. Each entry returns the physical frame and the read and write permissions for that page. A requester presents a domain and a 4 KB page number. One cycle later it receives hit or miss, the frame and the permissions. On a miss, logic outside the block walks the translation tables and loads the result through the fill port. A fill replaces the entries in strict rotation.

Software removes stale translations through one 64-bit command register. Writing the register with bit 63 set starts an invalidation. The invalidation removes either every entry or only the entries of one domain. It can also wait until all outstanding DMA reads, writes, or both, have finished. Bit 63 reads back as 1 for as long as the invalidation is in progress. The block clears bit 63 when the work is complete, so software can poll it. While an invalidation is in progress, every lookup is answered as a miss, fills are dropped and further register writes are ignored.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is empty, the command register reads 0 and no response is valid.
- R2: A fill that arrives while no invalidation is in progress writes the entry named by a rotating pointer. The pointer starts at 0 and visits entries 0 to 7 in turn, so the ninth fill overwrites the entry written by the first.
- R3: A lookup gets its response in the next cycle (`rsp_valid`). The response is a hit when a valid entry has the same domain and page number. A hit returns the entry's frame, read permission and write permission. A miss returns 0 for the frame and for both permissions.
- R4: An entry filled with the large flag compares only page bits 35:9, which are address bits 47:21. On a hit it returns the stored frame bits 35:9 joined with the lookup page bits 8:0.
- R5: Writing the register while idle stores bits 62:0. If bit 63 of the written value is 1, an invalidation starts. Reading bit 63 returns 1 from the edge of the write until the edge at which the invalidation finishes. The fields are: bits 47:32 domain, bits 49:48 scope, bit 52 wait for reads, bit 53 wait for writes.
- R6: Scope 01 removes every entry.
- R7: Scope 10 removes only the entries whose domain equals the domain field.
- R8: Scope 00 or scope 11 finishes at the first edge after the start, removes no entry and ignores both wait bits.
- R9: With bit 52 set, the invalidation does not finish while `rd_pending` is high. With bit 53 set, it does not finish while `wr_pending` is high. The invalidation finishes at the first edge at which no selected wait is blocked.
- R10: While an invalidation is in progress, lookups return a miss, fills are dropped and register writes are ignored.
- R11: When several valid entries match a lookup, the entry with the lowest index answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_dom | input | 16 | Lookup domain |
| lk_vpn | input | 36 | Lookup 4 KB page number (address bits 47:12) |
| fill_valid | input | 1 | Fill request |
| fill_dom | input | 16 | Fill domain |
| fill_vpn | input | 36 | Fill page number |
| fill_large | input | 1 | Fill is a 2 MB page |
| fill_frame | input | 36 | Physical frame number |
| fill_rd | input | 1 | Read allowed |
| fill_wr | input | 1 | Write allowed |
| reg_wr | input | 1 | Command register write strobe |
| reg_wdata | input | 64 | Command register write data |
| reg_rdata | output | 64 | Command register read value; bit 63 shows an invalidation in progress |
| rd_pending | input | 1 | DMA reads are outstanding |
| wr_pending | input | 1 | DMA writes are outstanding |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_frame | output | 36 | Translated frame number |
| rsp_rd | output | 1 | Read permission of the hit |
| rsp_wr | output | 1 | Write permission of the hit |

## Verification
The timing of each result is as follows:
- A lookup response appears on the outputs after the clock edge that follows the request.
- A fill can first be hit by a lookup made in the cycle after the fill.
- Bit 63 of the command register reads 1 after the edge of the write.
- An invalidation's removals and the clearing of bit 63 take effect together. This happens at the first edge at which the selected waits are not blocked.

The bench's reference model updates at the same rising edge as the design. It compares every output at the following falling edge, so each comparison sees exactly the results due in that cycle. A few directed checks with fixed expected values confirm the reset state, the frame composition of a 2 MB entry, and the go bit held high through a blocked wait.

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [15:0]       lk_dom,
  input  logic [ADDR_W-13:0] lk_vpn,
  input  logic              fill_valid,
  input  logic [15:0]       fill_dom,
  input  logic [ADDR_W-13:0] fill_vpn,
  input  logic              fill_large,
  input  logic [ADDR_W-13:0] fill_frame,
  input  logic              fill_rd,
  input  logic              fill_wr,
  input  logic              reg_wr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  input  logic              rd_pending,
  input  logic              wr_pending,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [ADDR_W-13:0] rsp_frame,
  output logic              rsp_rd,
  output logic              rsp_wr
);
  localparam int FRM_W = ADDR_W - 12;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] v_q, lg_q, rd_q, wr_q;
  logic [15:0]        dom_q [ENTRIES];
  logic [FRM_W-1:0]   tag_q [ENTRIES];
  logic [FRM_W-1:0]   frm_q [ENTRIES];
  logic [IDX_W-1:0]   ptr_q;
  logic [62:0]        cmd_q;
  logic               busy_q;

  logic [ENTRIES-1:0] match, kill;
  logic [IDX_W-1:0]   sel;
  logic [1:0]         scope;
  logic               blocked, reserved, done;

  assign scope    = cmd_q[49:48];
  assign reserved = (scope == 2'b00) || (scope == 2'b11);
  assign blocked  = (cmd_q[52] && rd_pending) || (cmd_q[53] && wr_pending);
  assign done     = busy_q && (reserved || !blocked);
  assign reg_rdata = {busy_q, cmd_q};

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign match[i] = v_q[i] && (dom_q[i] == lk_dom) &&
                      (lg_q[i] ? (tag_q[i][FRM_W-1:9] == lk_vpn[FRM_W-1:9])
                               : (tag_q[i] == lk_vpn));
    assign kill[i]  = v_q[i] && ((scope == 2'b01) ||
                      (scope == 2'b10 && dom_q[i] == cmd_q[47:32]));
  end

  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) sel = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0; lg_q <= '0; rd_q <= '0; wr_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        dom_q[i] <= '0; tag_q[i] <= '0; frm_q[i] <= '0;
      end
      ptr_q <= '0; cmd_q <= '0; busy_q <= 1'b0;
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_frame <= '0;
      rsp_rd <= 1'b0; rsp_wr <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      if (lk_valid && !busy_q && |match) begin
        rsp_hit   <= 1'b1;
        rsp_frame <= lg_q[sel] ? {frm_q[sel][FRM_W-1:9], lk_vpn[8:0]} : frm_q[sel];
        rsp_rd    <= rd_q[sel];
        rsp_wr    <= wr_q[sel];
      end else begin
        rsp_hit <= 1'b0; rsp_frame <= '0; rsp_rd <= 1'b0; rsp_wr <= 1'b0;
      end
      if (busy_q) begin
        if (done) begin
          v_q    <= v_q & ~kill;
          busy_q <= 1'b0;
        end
      end else begin
        if (fill_valid) begin
          v_q[ptr_q]   <= 1'b1;
          lg_q[ptr_q]  <= fill_large;
          rd_q[ptr_q]  <= fill_rd;
          wr_q[ptr_q]  <= fill_wr;
          dom_q[ptr_q] <= fill_dom;
          tag_q[ptr_q] <= fill_vpn;
          frm_q[ptr_q] <= fill_frame;
          ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
        if (reg_wr) begin
          cmd_q  <= reg_wdata[62:0];
          busy_q <= reg_wdata[63];
        end
      end
    end
  end

  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !reserved && blocked |=> busy_q); // R9
  AST_BUSY_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && busy_q |=> !rsp_hit); // R10
  AST_GLOBAL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && scope == 2'b01 && !blocked |=> v_q == '0); // R6
  AST_RESERVED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && reserved |=> !busy_q && v_q == $past(v_q)); // R8
  AST_MISS_NO_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> !rsp_rd && !rsp_wr && rsp_frame == '0); // R3
  AST_HIT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid); // R3
endmodule

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;
  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, fill_valid = 0, fill_large = 0, fill_rd = 0, fill_wr = 0;
  logic reg_wr = 0, rd_pending = 0, wr_pending = 0;
  logic [15:0] lk_dom = 0, fill_dom = 0;
  logic [35:0] lk_vpn = 0, fill_vpn = 0, fill_frame = 0;
  logic [63:0] reg_wdata = 0, reg_rdata;
  logic rsp_valid, rsp_hit, rsp_rd, rsp_wr;
  logic [35:0] rsp_frame;

  xlat_cache u0 (.*);

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  string cur_req = "R1";

  bit        m_v [8], m_lg [8], m_rd [8], m_wr [8];
  bit [15:0] m_dom [8];
  bit [35:0] m_tag [8], m_frm [8];
  int        m_ptr;
  bit        m_busy;
  bit [62:0] m_cmd;
  bit        e_valid, e_hit, e_rd, e_wr;
  bit [35:0] e_frame;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_v[i]) m_v[i] = 0;
      m_ptr = 0; m_busy = 0; m_cmd = 0;
      e_valid = 0; e_hit = 0; e_rd = 0; e_wr = 0; e_frame = 0;
    end else begin
      int idx;
      idx = -1;
      for (int i = 0; i < 8; i++)
        if (idx < 0 && m_v[i] && m_dom[i] == lk_dom &&
            (m_lg[i] ? (m_tag[i] >> 9) == (lk_vpn >> 9) : m_tag[i] == lk_vpn))
          idx = i;
      e_valid = lk_valid;
      e_hit = lk_valid && !m_busy && idx >= 0;
      if (e_hit) begin
        e_frame = m_lg[idx] ? ((m_frm[idx] >> 9) << 9) | (lk_vpn & 36'h1ff) : m_frm[idx];
        e_rd = m_rd[idx]; e_wr = m_wr[idx];
      end else begin
        e_frame = 0; e_rd = 0; e_wr = 0;
      end
      if (m_busy) begin
        int sc;
        sc = m_cmd[49:48];
        if (sc == 0 || sc == 3) m_busy = 0;
        else if (!(m_cmd[52] && rd_pending) && !(m_cmd[53] && wr_pending)) begin
          for (int i = 0; i < 8; i++)
            if (sc == 1 || m_dom[i] == m_cmd[47:32]) m_v[i] = 0;
          m_busy = 0;
        end
      end else begin
        if (fill_valid) begin
          m_v[m_ptr] = 1; m_lg[m_ptr] = fill_large; m_rd[m_ptr] = fill_rd;
          m_wr[m_ptr] = fill_wr; m_dom[m_ptr] = fill_dom;
          m_tag[m_ptr] = fill_vpn; m_frm[m_ptr] = fill_frame;
          m_ptr = (m_ptr + 1) % 8;
        end
        if (reg_wr) begin
          m_cmd = reg_wdata[62:0];
          m_busy = reg_wdata[63];
        end
      end
    end
  end

  task automatic chk(string what, logic [63:0] got, logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %0h expected %0h", cur_req, what, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("rsp_valid", rsp_valid, e_valid);
    chk("rsp_hit", rsp_hit, e_hit);
    chk("rsp_frame", rsp_frame, e_frame);
    chk("rsp_rd", rsp_rd, e_rd);
    chk("rsp_wr", rsp_wr, e_wr);
    chk("reg_rdata", reg_rdata, {m_busy, m_cmd});
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic fill(bit [15:0] d, bit [35:0] vpn, bit lg, bit [35:0] frm, bit r, bit w);
    fill_valid = 1; fill_dom = d; fill_vpn = vpn; fill_large = lg;
    fill_frame = frm; fill_rd = r; fill_wr = w;
    @(negedge clk); fill_valid = 0;
  endtask
  task automatic look(bit [15:0] d, bit [35:0] vpn);
    lk_valid = 1; lk_dom = d; lk_vpn = vpn;
    @(negedge clk); lk_valid = 0;
  endtask
  task automatic wreg(bit [63:0] v);
    reg_wr = 1; reg_wdata = v;
    @(negedge clk); reg_wr = 0;
  endtask
  function automatic bit [63:0] cmd(bit go, bit [1:0] sc, bit [15:0] d, bit dr, bit dw);
    return {go, 9'd0, dw, dr, 2'd0, sc, d, 32'd0};
  endfunction

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(2);
    cur_req = "R1";
    chk("reset reg", reg_rdata, 64'd0);
    chk("reset rsp_valid", rsp_valid, 1'b0);
    look(16'd5, 36'd3); idle(1);

    cur_req = "R2";
    for (int i = 0; i < 8; i++) fill(16'd5, 36'(i * 16 + 3), 0, 36'(256 + i), i[0], i[1]);
    cur_req = "R3";
    for (int i = 0; i < 8; i++) look(16'd5, 36'(i * 16 + 3));
    look(16'd6, 36'd3); look(16'd5, 36'd4);
    cur_req = "R2";
    fill(16'd5, 36'h999, 0, 36'h777, 1, 1);
    look(16'd5, 36'd3); look(16'd5, 36'h999); look(16'd5, 36'd19);

    cur_req = "R4";
    fill(16'd7, 36'h0_0040_0000, 1, 36'hABCDE_F123, 1, 0);
    look(16'd7, 36'h0_0040_0155);
    chk("large frame R4", rsp_frame, 36'hABCDE_F155);
    look(16'd7, 36'h0_0040_0255); look(16'd8, 36'h0_0040_0000);

    cur_req = "R11";
    fill(16'd5, 36'd35, 0, 36'h555, 0, 1);
    look(16'd5, 36'd35);

    cur_req = "R5";
    wreg(cmd(1, 2'b01, 16'd0, 0, 0));
    chk("go bit R5", reg_rdata[63], 1'b1);
    idle(1);
    chk("go clear R5", reg_rdata[63], 1'b0);
    cur_req = "R6";
    for (int i = 0; i < 8; i++) look(16'd5, 36'(i * 16 + 3));
    look(16'd7, 36'h0_0040_0000);

    cur_req = "R7";
    for (int i = 0; i < 8; i++) fill(16'(i[0] ? 9 : 5), 36'(i), 0, 36'(i + 64), 1, 1);
    wreg(cmd(1, 2'b10, 16'd9, 0, 0)); idle(1);
    for (int i = 0; i < 8; i++) look(16'(i[0] ? 9 : 5), 36'(i));

    cur_req = "R8";
    rd_pending = 1; wr_pending = 1;
    wreg(cmd(1, 2'b00, 16'd5, 1, 1)); idle(1);
    wreg(cmd(1, 2'b11, 16'd5, 1, 1)); idle(1);
    for (int i = 0; i < 8; i += 2) look(16'd5, 36'(i));

    cur_req = "R9";
    wreg(cmd(1, 2'b10, 16'd5, 1, 0));
    idle(4);
    chk("held go R9", reg_rdata[63], 1'b1);
    cur_req = "R10";
    look(16'd5, 36'd0);
    fill(16'd3, 36'd77, 0, 36'd1, 1, 1);
    wreg(cmd(1, 2'b01, 16'd0, 0, 0));
    cur_req = "R9";
    rd_pending = 0; idle(2);
    wreg(cmd(1, 2'b01, 16'd0, 0, 1)); idle(3);
    wr_pending = 0; idle(2);
    cur_req = "R10";
    look(16'd3, 36'd77);

    cur_req = "R3";
    for (int n = 0; n < 4000; n++) begin
      lk_valid = 1'($urandom_range(0, 1));
      lk_dom = 16'($urandom_range(1, 3));
      lk_vpn = 36'($urandom_range(0, 7)) | (36'($urandom_range(0, 1)) << 9);
      fill_valid = 1'($urandom_range(0, 2) == 0);
      fill_dom = 16'($urandom_range(1, 3));
      fill_vpn = 36'($urandom_range(0, 7));
      fill_large = 1'($urandom_range(0, 3) == 0);
      fill_frame = 36'($urandom);
      fill_rd = 1'($urandom); fill_wr = 1'($urandom);
      reg_wr = 1'($urandom_range(0, 15) == 0);
      reg_wdata = cmd(1'($urandom), 2'($urandom), 16'($urandom_range(1, 3)),
                      1'($urandom), 1'($urandom));
      rd_pending = 1'($urandom_range(0, 2) == 0);
      wr_pending = 1'($urandom_range(0, 2) == 0);
      @(negedge clk);
    end
    lk_valid = 0; fill_valid = 0; reg_wr = 0; rd_pending = 0; wr_pending = 0;
    idle(3);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule